// File: doc/BRIEF.md
# Sector Read-Modify-Write Engine

This block lets a host write an arbitrary run of bytes into flash that can only be erased a whole sector at a time. A start pulse carries a byte offset and a byte length. The sector geometry is supplied on the same pulse: sector size, program page length and sector count. The new bytes arrive on a valid/ready byte stream. The engine visits every sector the run touches, in increasing address order. For each one it fetches the full sector into a local single-port buffer and overwrites the affected bytes in place. It then erases the sector and programs the buffer back in page-limited bursts.

The engine does not drive the flash itself. It issues read, erase and program requests to a separate command sequencer. Read data comes back on a byte input, and program data leaves on a byte output with its own handshake. Each request ends with a completion flag that carries an error bit. When the operation ends, the engine pulses done together with a pass flag and the number of bytes it accepted.

Top module: `sector_rmw_engine`

## Requirements
- R1: After reset, and between operations, `busy_o`, `done_o`, `req_valid_o`, `din_ready_o` and `wr_valid_o` are all low.
- R2: A start is rejected when any of these holds: length is zero; sector size is zero or larger than MAX_SECT_BYTES; page length is zero; offset+length−1 ≥ sector count × sector size. A rejected start pulses `done_o` with `ok_o` low and a count of 0. It issues no flash request, takes no stream byte and leaves flash contents unchanged.
- R3: Sectors floor(offset/size) through floor((offset+length−1)/size) are handled in increasing order. Each sector gets a read request (op code 0) for its base address and full size, then an erase request (op code 1) for the same base and size, then program requests (op code 2).
- R4: Within a sector, the bytes from max(base, offset) to min(base+size−1, offset+length−1) take the stream bytes. Every other byte of the device keeps its previous content.
- R5: Program bursts of a sector start at its base. Each burst has length min(page length, bytes left in the sector). The next burst's address advances by the length just sent.
- R6: Stream bytes are taken in address order, exactly `length` of them across all sectors. `din_ready_o` is high only while busy and while no request is pending.
- R7: A completion flagged as an error, on a read, erase or program, ends the operation. No further request is issued, and `done_o` pulses with `ok_o` low and a count of 0.
- R8: On success `done_o` is high for exactly one cycle, with `ok_o` high and `acc_o` equal to the length.
- R9: A request that is not yet accepted keeps its op code, address and length stable. A program byte that is not yet accepted keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| offset_i | input | ADDR_W | First byte address of the run |
| length_i | input | ADDR_W | Number of bytes in the run |
| sect_size_i | input | SZ_W | Sector size in bytes |
| page_len_i | input | SZ_W | Maximum program burst length |
| sect_cnt_i | input | CNT_W | Number of sectors in the device |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| ok_o | output | 1 | Operation succeeded (valid with done) |
| acc_o | output | ADDR_W | Bytes accepted, zero on failure (valid with done) |
| din_valid_i | input | 1 | Stream byte valid |
| din_data_i | input | 8 | Stream byte |
| din_ready_o | output | 1 | Stream byte taken when valid and ready |
| req_valid_o | output | 1 | Flash request valid |
| req_ready_i | input | 1 | Flash request accepted |
| req_op_o | output | 2 | 0 read, 1 erase, 2 program |
| req_addr_o | output | ADDR_W | Request start address |
| req_len_o | output | SZ_W | Request byte count |
| rd_valid_i | input | 1 | Read data byte valid |
| rd_data_i | input | 8 | Read data byte |
| wr_valid_o | output | 1 | Program byte valid |
| wr_data_o | output | 8 | Program byte |
| wr_ready_i | input | 1 | Program byte accepted |
| cmp_valid_i | input | 1 | Request completion |
| cmp_err_i | input | 1 | Completion carries an error |

## Verification
The properties rely on a well-behaved sequencer. After a read is accepted, it returns exactly the requested number of bytes and only then signals completion. A program completes only after every byte has been taken. Exactly one completion follows each accepted request. Geometry and offset inputs are assumed valid in the cycle of the start pulse. The bench keeps to these rules with a behavioural sequencer and flash array. That model holds back request acceptance by one cycle and refuses every other program byte, so the hold rules are exercised. Errors are injected only through the completion flag, at a chosen request number.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2
  } flash_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FIND,
    ST_RD_REQ,
    ST_RD_DATA,
    ST_RD_WAIT,
    ST_OVL,
    ST_ER_REQ,
    ST_ER_WAIT,
    ST_PG_REQ,
    ST_PG_FETCH,
    ST_PG_DATA,
    ST_PG_WAIT,
    ST_FIN
  } rmw_state_e;
endpackage

// File: rtl/rmw_sect_ram.sv
module rmw_sect_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  // single port: a write cycle produces no read
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    else if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/rmw_bounds.sv
module rmw_bounds #(
  parameter int ADDR_W         = 24,
  parameter int SZ_W           = 9,
  parameter int CNT_W          = 16,
  parameter int MAX_SECT_BYTES = 256
) (
  input  logic [ADDR_W-1:0] off_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [SZ_W-1:0]   page_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              bad_o,
  output logic [ADDR_W-1:0] last_o
);
  localparam int PW = CNT_W + SZ_W;
  localparam int CW = ((PW > ADDR_W + 1) ? PW : ADDR_W + 1) + 1;
  localparam logic [CW-1:0] ONE_C = 1;

  logic [CW-1:0] end_w, dev_w;

  always_comb begin
    end_w  = CW'(off_i) + CW'(len_i) - ONE_C;
    dev_w  = CW'(cnt_i) * CW'(size_i);
    last_o = end_w[ADDR_W-1:0];
    bad_o  = (len_i == '0) || (size_i == '0) || (page_i == '0) ||
             (32'(size_i) > MAX_SECT_BYTES) || (end_w >= dev_w);
  end
endmodule

// File: rtl/rmw_fsm.sv
module rmw_fsm
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SZ_W   = 9,
  parameter int RAM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [SZ_W-1:0]   page_i,
  input  logic              bad_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic [ADDR_W-1:0] acc_o,
  input  logic              din_valid_i,
  input  logic [7:0]        din_data_i,
  output logic              din_ready_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [1:0]        req_op_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [SZ_W-1:0]   req_len_o,
  input  logic              rd_valid_i,
  input  logic [7:0]        rd_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  input  logic              cmp_valid_i,
  input  logic              cmp_err_i,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o
);
  localparam logic [ADDR_W:0]   ONE_A  = 1;
  localparam logic [ADDR_W-1:0] ONE_AC = 1;
  localparam logic [SZ_W-1:0]   ONE_S  = 1;

  rmw_state_e        state_q;
  logic [ADDR_W-1:0] off_q, last_q, base_q, acc_q;
  logic [SZ_W-1:0]   size_q, page_q, idx_q, rem_q;
  logic              ok_q;

  logic [ADDR_W:0]   base_nxt, sect_end;
  logic [SZ_W-1:0]   lo, hi, avail, blen;

  always_comb begin
    base_nxt = {1'b0, base_q} + (ADDR_W+1)'(size_q);
    sect_end = base_nxt - ONE_A;
    lo       = (base_q < off_q) ? SZ_W'(off_q - base_q) : '0;
    hi       = (sect_end > {1'b0, last_q}) ? SZ_W'(last_q - base_q) : size_q - ONE_S;
    avail    = size_q - idx_q;
    blen     = (page_q < avail) ? page_q : avail;
  end

  always_comb begin
    req_valid_o = 1'b0;
    req_op_o    = OP_READ;
    req_addr_o  = base_q;
    req_len_o   = size_q;
    unique case (state_q)
      ST_RD_REQ: req_valid_o = 1'b1;
      ST_ER_REQ: begin
        req_valid_o = 1'b1;
        req_op_o    = OP_ERASE;
      end
      ST_PG_REQ: begin
        req_valid_o = 1'b1;
        req_op_o    = OP_PROG;
        req_addr_o  = base_q + ADDR_W'(idx_q);
        req_len_o   = blen;
      end
      default: ;
    endcase
  end

  assign din_ready_o = (state_q == ST_OVL);
  assign wr_valid_o  = (state_q == ST_PG_DATA);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign ok_o        = ok_q;
  assign acc_o       = acc_q;

  assign ram_we_o    = ((state_q == ST_RD_DATA) && rd_valid_i) ||
                       ((state_q == ST_OVL) && din_valid_i);
  assign ram_re_o    = (state_q == ST_PG_FETCH);
  assign ram_addr_o  = idx_q[RAM_AW-1:0];
  assign ram_wdata_o = (state_q == ST_OVL) ? din_data_i : rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
      last_q  <= '0;
      base_q  <= '0;
      acc_q   <= '0;
      size_q  <= '0;
      page_q  <= '0;
      idx_q   <= '0;
      rem_q   <= '0;
      ok_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          off_q   <= offset_i;
          last_q  <= last_i;
          size_q  <= size_i;
          page_q  <= page_i;
          base_q  <= '0;
          acc_q   <= '0;
          ok_q    <= 1'b0;
          state_q <= bad_i ? ST_FIN : ST_FIND;
        end
        // walk to the first touched sector, one sector per cycle
        ST_FIND: begin
          if (base_nxt <= {1'b0, off_q}) base_q <= base_nxt[ADDR_W-1:0];
          else state_q <= ST_RD_REQ;
        end
        ST_RD_REQ: if (req_ready_i) begin
          idx_q   <= '0;
          state_q <= ST_RD_DATA;
        end
        ST_RD_DATA: begin
          if (cmp_valid_i && cmp_err_i) begin
            acc_q   <= '0;
            state_q <= ST_FIN;
          end else if (rd_valid_i) begin
            idx_q <= idx_q + ONE_S;
            if (idx_q == size_q - ONE_S) state_q <= ST_RD_WAIT;
          end
        end
        ST_RD_WAIT: if (cmp_valid_i) begin
          if (cmp_err_i) begin
            acc_q   <= '0;
            state_q <= ST_FIN;
          end else begin
            idx_q   <= lo;
            state_q <= ST_OVL;
          end
        end
        ST_OVL: if (din_valid_i) begin
          acc_q <= acc_q + ONE_AC;
          if (idx_q == hi) state_q <= ST_ER_REQ;
          else idx_q <= idx_q + ONE_S;
        end
        ST_ER_REQ: if (req_ready_i) state_q <= ST_ER_WAIT;
        ST_ER_WAIT: if (cmp_valid_i) begin
          if (cmp_err_i) begin
            acc_q   <= '0;
            state_q <= ST_FIN;
          end else begin
            idx_q   <= '0;
            state_q <= ST_PG_REQ;
          end
        end
        ST_PG_REQ: if (req_ready_i) begin
          rem_q   <= blen;
          state_q <= ST_PG_FETCH;
        end
        ST_PG_FETCH: state_q <= ST_PG_DATA;
        ST_PG_DATA: if (wr_ready_i) begin
          idx_q   <= idx_q + ONE_S;
          rem_q   <= rem_q - ONE_S;
          state_q <= (rem_q == ONE_S) ? ST_PG_WAIT : ST_PG_FETCH;
        end
        ST_PG_WAIT: if (cmp_valid_i) begin
          if (cmp_err_i) begin
            acc_q   <= '0;
            state_q <= ST_FIN;
          end else if (idx_q != size_q) begin
            state_q <= ST_PG_REQ;
          end else if (sect_end >= {1'b0, last_q}) begin
            ok_q    <= 1'b1;
            state_q <= ST_FIN;
          end else begin
            base_q  <= base_nxt[ADDR_W-1:0];
            state_q <= ST_RD_REQ;
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sector_rmw_engine.sv
module sector_rmw_engine #(
  parameter int ADDR_W         = 24,
  parameter int MAX_SECT_BYTES = 256,
  parameter int CNT_W          = 16
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    start_i,
  input  logic [ADDR_W-1:0]                       offset_i,
  input  logic [ADDR_W-1:0]                       length_i,
  input  logic [$clog2(MAX_SECT_BYTES+1)-1:0]     sect_size_i,
  input  logic [$clog2(MAX_SECT_BYTES+1)-1:0]     page_len_i,
  input  logic [CNT_W-1:0]                        sect_cnt_i,
  output logic                                    busy_o,
  output logic                                    done_o,
  output logic                                    ok_o,
  output logic [ADDR_W-1:0]                       acc_o,
  input  logic                                    din_valid_i,
  input  logic [7:0]                              din_data_i,
  output logic                                    din_ready_o,
  output logic                                    req_valid_o,
  input  logic                                    req_ready_i,
  output logic [1:0]                              req_op_o,
  output logic [ADDR_W-1:0]                       req_addr_o,
  output logic [$clog2(MAX_SECT_BYTES+1)-1:0]     req_len_o,
  input  logic                                    rd_valid_i,
  input  logic [7:0]                              rd_data_i,
  output logic                                    wr_valid_o,
  output logic [7:0]                              wr_data_o,
  input  logic                                    wr_ready_i,
  input  logic                                    cmp_valid_i,
  input  logic                                    cmp_err_i
);
  localparam int SZ_W   = $clog2(MAX_SECT_BYTES + 1);
  localparam int RAM_AW = (MAX_SECT_BYTES > 1) ? $clog2(MAX_SECT_BYTES) : 1;

  logic              bad;
  logic [ADDR_W-1:0] last;
  logic              ram_we, ram_re;
  logic [RAM_AW-1:0] ram_addr;
  logic [7:0]        ram_wdata;

  rmw_bounds #(
    .ADDR_W(ADDR_W), .SZ_W(SZ_W), .CNT_W(CNT_W), .MAX_SECT_BYTES(MAX_SECT_BYTES)
  ) bounds_i (
    .off_i (offset_i),
    .len_i (length_i),
    .size_i(sect_size_i),
    .page_i(page_len_i),
    .cnt_i (sect_cnt_i),
    .bad_o (bad),
    .last_o(last)
  );

  rmw_fsm #(
    .ADDR_W(ADDR_W), .SZ_W(SZ_W), .RAM_AW(RAM_AW)
  ) fsm_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .offset_i   (offset_i),
    .size_i     (sect_size_i),
    .page_i     (page_len_i),
    .bad_i      (bad),
    .last_i     (last),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ok_o       (ok_o),
    .acc_o      (acc_o),
    .din_valid_i(din_valid_i),
    .din_data_i (din_data_i),
    .din_ready_o(din_ready_o),
    .req_valid_o(req_valid_o),
    .req_ready_i(req_ready_i),
    .req_op_o   (req_op_o),
    .req_addr_o (req_addr_o),
    .req_len_o  (req_len_o),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .cmp_valid_i(cmp_valid_i),
    .cmp_err_i  (cmp_err_i),
    .ram_we_o   (ram_we),
    .ram_re_o   (ram_re),
    .ram_addr_o (ram_addr),
    .ram_wdata_o(ram_wdata)
  );

  rmw_sect_ram #(
    .DEPTH(MAX_SECT_BYTES), .AW(RAM_AW)
  ) ram_i (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .re_i   (ram_re),
    .addr_i (ram_addr),
    .wdata_i(ram_wdata),
    .rdata_o(wr_data_o)
  );
endmodule

// File: rtl/rmw_chk.sv
module rmw_chk #(
  parameter int ADDR_W = 24,
  parameter int SZ_W   = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [SZ_W-1:0]   page_len_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              ok_o,
  input logic [ADDR_W-1:0] acc_o,
  input logic              din_ready_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [1:0]        req_op_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [SZ_W-1:0]   req_len_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [7:0]        wr_data_o,
  input logic              cmp_valid_i,
  input logic              cmp_err_i
);
  logic [SZ_W-1:0] page_q;
  logic            rd_seen_q, err_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q     <= '0;
      rd_seen_q  <= 1'b0;
      err_seen_q <= 1'b0;
    end else begin
      if (start_i && !busy_o) page_q <= page_len_i;
      if (req_valid_o && req_ready_i && req_op_o == 2'd0) rd_seen_q <= 1'b1;
      else if (req_valid_o && req_ready_i && req_op_o == 2'd1) rd_seen_q <= 1'b0;
      if (cmp_valid_i && cmp_err_i) err_seen_q <= 1'b1;
      else if (done_o) err_seen_q <= 1'b0;
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_op_o) &&
    $stable(req_addr_o) && $stable(req_len_o));

  assert_wr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_data_o));

  assert_burst_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_op_o == 2'd2 |-> req_len_o != '0 && req_len_o <= page_q);

  assert_erase_after_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_op_o == 2'd1 |-> rd_seen_q);

  assert_fail_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !ok_o |-> acc_o == '0);

  assert_no_req_after_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !err_seen_q);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_din_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    din_ready_o |-> busy_o && !req_valid_o);
endmodule

bind sector_rmw_engine rmw_chk #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .page_len_i (page_len_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .ok_o       (ok_o),
  .acc_o      (acc_o),
  .din_ready_o(din_ready_o),
  .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i),
  .req_op_o   (req_op_o),
  .req_addr_o (req_addr_o),
  .req_len_o  (req_len_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_data_o  (wr_data_o),
  .cmp_valid_i(cmp_valid_i),
  .cmp_err_i  (cmp_err_i)
);

// File: tb/sector_rmw_engine_tb_top.sv
module sector_rmw_engine_tb_top;
  localparam int ADDR_W   = 24;
  localparam int MAX_SECT = 256;
  localparam int CNT_W    = 16;
  localparam int SZ_W     = $clog2(MAX_SECT + 1);
  localparam int MEM_N    = 1024;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] offset = '0, length = '0;
  logic [SZ_W-1:0]   sect_size = '0, page_len = '0;
  logic [CNT_W-1:0]  sect_cnt = '0;
  logic              busy, done, ok;
  logic [ADDR_W-1:0] acc;
  logic              din_valid = 1'b0;
  logic [7:0]        din_data = '0;
  logic              din_ready;
  logic              req_valid, req_ready = 1'b0;
  logic [1:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [SZ_W-1:0]   req_len;
  logic              rd_valid = 1'b0;
  logic [7:0]        rd_data = '0;
  logic              wr_valid, wr_ready = 1'b0;
  logic [7:0]        wr_data;
  logic              cmp_valid = 1'b0, cmp_err = 1'b0;

  always #5 clk = ~clk;

  sector_rmw_engine #(.ADDR_W(ADDR_W), .MAX_SECT_BYTES(MAX_SECT), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .offset_i(offset), .length_i(length),
    .sect_size_i(sect_size), .page_len_i(page_len), .sect_cnt_i(sect_cnt),
    .busy_o(busy), .done_o(done), .ok_o(ok), .acc_o(acc),
    .din_valid_i(din_valid), .din_data_i(din_data), .din_ready_o(din_ready),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_op_o(req_op),
    .req_addr_o(req_addr), .req_len_o(req_len),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_data_o(wr_data), .wr_ready_i(wr_ready),
    .cmp_valid_i(cmp_valid), .cmp_err_i(cmp_err)
  );

  int checks = 0, errors = 0;
  logic [7:0] fmem [MEM_N];
  logic [7:0] exp_mem [MEM_N];
  logic [7:0] src [MEM_N];
  int k = 0, n = 0, take = 0, seed = 11;
  int exp_op[$], exp_addr[$], exp_len[$];
  int mode = 0, cur_mode = 0, ra = 0, rl = 0, ri = 0, cmd_no = 0, err_inj = -1;
  bit inject = 1'b0, ptog = 1'b0;

  task automatic chk(input bit cond, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // behavioural command sequencer and flash array, all driving on negedge
  initial begin
    for (int i = 0; i < MEM_N; i++) fmem[i] = 8'((i * 7 + 3) % 251);
    forever begin
      @(negedge clk);
      rd_valid  = 1'b0;
      cmp_valid = 1'b0;
      cmp_err   = 1'b0;
      wr_ready  = 1'b0;
      if (take != 0) k++;
      take      = 0;
      din_valid = (k < n);
      din_data  = src[(k < MEM_N) ? k : 0];
      if (din_valid && din_ready) take = 1;
      if (mode == 2) begin
        req_ready = 1'b0;
        mode      = cur_mode;
      end
      case (mode)
        0: if (req_valid) begin
          if (exp_op.size() == 0) begin
            chk(1'b0, "R7", "unexpected request addr", longint'(req_addr), -1);
          end else begin
            chk(int'(req_op) == exp_op[0] && int'(req_addr) == exp_addr[0] &&
                int'(req_len) == exp_len[0], (exp_op[0] == 2) ? "R5" : "R3",
                "request addr/len", longint'(req_addr) * 1000 + longint'(req_len),
                longint'(exp_addr[0]) * 1000 + longint'(exp_len[0]));
            void'(exp_op.pop_front());
            void'(exp_addr.pop_front());
            void'(exp_len.pop_front());
          end
          ra       = int'(req_addr);
          rl       = int'(req_len);
          ri       = 0;
          cur_mode = (req_op == 2'd0) ? 3 : (req_op == 2'd1) ? 4 : 5;
          inject   = (cmd_no == err_inj);
          cmd_no++;
          mode     = 1;
        end
        1: begin
          req_ready = 1'b1;
          mode      = 2;
        end
        3: begin
          if (ri < rl) begin
            rd_valid = 1'b1;
            rd_data  = fmem[ra + ri];
            ri++;
          end else begin
            cmp_valid = 1'b1;
            cmp_err   = inject;
            mode      = 0;
          end
        end
        4: begin
          if (ri < 2) ri++;
          else begin
            for (int i = 0; i < rl; i++) fmem[ra + i] = 8'hFF;
            cmp_valid = 1'b1;
            cmp_err   = inject;
            mode      = 0;
          end
        end
        5: begin
          if (ri < rl) begin
            ptog     = ~ptog;
            wr_ready = ptog;
            if (ptog && wr_valid) begin
              fmem[ra + ri] = wr_data;
              ri++;
            end
          end else begin
            cmp_valid = 1'b1;
            cmp_err   = inject;
            mode      = 0;
          end
        end
        default: ;
      endcase
    end
  end

  task automatic run_op(input int off, input int len, input int size, input int page,
                        input int cnt, input int err_at);
    bit    bad, exp_ok;
    int    wait_n, mism;
    string tag;
    bad = (len == 0) || (size == 0) || (size > MAX_SECT) || (page == 0) ||
          (off + len - 1 >= cnt * size);
    exp_op.delete();
    exp_addr.delete();
    exp_len.delete();
    if (!bad) begin
      for (int s = off / size; s <= (off + len - 1) / size; s++) begin
        int p;
        exp_op.push_back(0); exp_addr.push_back(s * size); exp_len.push_back(size);
        exp_op.push_back(1); exp_addr.push_back(s * size); exp_len.push_back(size);
        p = 0;
        while (p < size) begin
          int b;
          b = (page < size - p) ? page : size - p;
          exp_op.push_back(2); exp_addr.push_back(s * size + p); exp_len.push_back(b);
          p += b;
        end
      end
    end
    if (err_at >= 0) begin
      while (exp_op.size() > err_at + 1) begin
        void'(exp_op.pop_back());
        void'(exp_addr.pop_back());
        void'(exp_len.pop_back());
      end
    end
    for (int i = 0; i < len && i < MEM_N; i++) src[i] = 8'((i * 29 + seed) & 255);
    seed += 7;
    for (int i = 0; i < MEM_N; i++) exp_mem[i] = fmem[i];
    exp_ok = !bad && (err_at < 0);
    if (exp_ok) for (int i = 0; i < len; i++) exp_mem[off + i] = src[i];
    tag = bad ? "R2" : (err_at >= 0) ? "R7" : "R8";

    @(negedge clk);
    k         = 0;
    n         = len;
    cmd_no    = 0;
    err_inj   = err_at;
    offset    = ADDR_W'(off);
    length    = ADDR_W'(len);
    sect_size = SZ_W'(size);
    page_len  = SZ_W'(page);
    sect_cnt  = CNT_W'(cnt);
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    wait_n    = 0;
    while (!done && wait_n < 20000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(done, tag, "done seen", longint'(done), 1);
    chk(ok == exp_ok, tag, "ok flag", longint'(ok), longint'(exp_ok));
    chk(int'(acc) == (exp_ok ? len : 0), tag, "accepted count", longint'(acc),
        exp_ok ? len : 0);
    chk(exp_op.size() == 0, bad ? "R2" : "R3", "requests left", exp_op.size(), 0);
    if (exp_ok) chk(k == len, "R6", "stream bytes taken", k, len);
    if (bad) chk(k == 0, "R2", "stream bytes taken", k, 0);
    if (err_at < 0) begin
      mism = 0;
      for (int i = 0; i < MEM_N; i++) if (fmem[i] !== exp_mem[i]) mism++;
      chk(mism == 0, bad ? "R2" : "R4", "flash mismatches", mism, 0);
    end
    @(negedge clk);
    chk(!done && !busy, "R8", "done width / idle", longint'(done) + longint'(busy), 0);
    n = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !req_valid && !din_ready && !wr_valid, "R1", "idle outputs",
        longint'({busy, done, req_valid, din_ready, wr_valid}), 0);
    run_op(5, 6, 16, 4, 8, -1);      // inside one sector
    run_op(10, 40, 16, 5, 8, -1);    // partial first and last, uneven bursts
    run_op(32, 16, 16, 32, 8, -1);   // whole aligned sector, page above size
    run_op(127, 1, 16, 16, 8, -1);   // last device byte
    run_op(0, 1, 16, 3, 8, -1);      // first byte, bursts of 3 then 1
    run_op(64, 64, 32, 8, 4, -1);    // other geometry, ends on device end
    run_op(120, 9, 16, 4, 8, -1);    // end beyond device
    run_op(3, 0, 16, 4, 8, -1);      // zero length
    run_op(3, 4, 16, 0, 8, -1);      // zero page
    run_op(0, 1, 300, 4, 2, -1);     // sector above maximum
    run_op(40, 4, 16, 4, 8, 1);      // erase fails
    run_op(20, 30, 16, 4, 8, 9);     // program fails in second sector
    run_op(0, 2, 16, 4, 8, 0);       // read fails
    run_op(17, 20, 16, 4, 8, -1);    // clean run after failures
    @(negedge clk);
    chk(!busy && !req_valid && !din_ready, "R1", "idle after run",
        longint'({busy, req_valid, din_ready}), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule